// File: doc/BRIEF.md
# Stereo Audio Converter Serial Port

This block is the clock-master side of a serial link to a two-channel audio converter. From the system clock it makes a bit clock and a left/right frame clock. It sends a left and a right parallel sample out on one serial data line and collects the returning serial stream into a left and a right parallel sample. A frame lasts 256 system clocks and holds 64 bit periods, 32 for each channel.

One shifter serves four data layouts, chosen by a 2-bit format code. The code sets the sample width (16 or 20 bits), where the word sits inside its channel half, and which frame-clock level marks the left channel. The outgoing and incoming directions may use different layouts under the same code. A format change takes effect only at a frame boundary. Transmit samples are taken once per frame through a valid/ready handshake. The two received samples are delivered together with a one-cycle valid pulse.

Top module: `codec_serial_port`

## Requirements
- R1: The bit clock has a period of 4 system clocks. It is low for the first two clocks of each bit period and high for the last two, so every bit period starts with a falling edge.
- R2: A frame is 256 system clocks, which is 64 bit periods. The frame clock changes level only together with a bit-clock fall, and it changes at the start of slot 0 and of slot 32 of every frame.
- R3: The first half of the frame (slots 0..31) carries the left channel and the second half carries the right channel. For format codes 0, 1 and 2 the frame clock is high during the left half. For code 3 it is low during the left half.
- R4: Outgoing words are sent MSB first, one bit per slot. Slot numbers below count within a half. Code 0 sends bits 15..0 in slots 16..31. Code 1 sends bits 19..0 in slots 12..31. Code 2 sends bits 19..0 in slots 0..19. Code 3 sends bits 19..0 in slots 1..20.
- R5: Incoming words are taken MSB first. Code 0 captures slots 0..15 into bits 15..0 and returns bits 19..16 as zero. Codes 1 and 2 capture slots 0..19 into bits 19..0. Code 3 captures slots 1..20 into bits 19..0.
- R6: In every slot outside the outgoing window of the current format, the serial output is 0.
- R7: Incoming bits in slots outside the capture window have no effect on the received samples.
- R8: The serial output changes only in the cycle in which the bit clock falls. The serial input is sampled while the bit clock is high.
- R9: The format input is sampled only in the last system clock of a frame. It governs the whole next frame in both directions, and changes in mid-frame have no effect on the current frame.
- R10: tx_ready_o is high for exactly one system clock per frame: the last one. If tx_valid_i is high in that cycle, the two samples are sent in the next frame. Otherwise that frame sends zero words.
- R11: rx_valid_o pulses for one clock in the first cycle of the following frame, with both captured samples on rx_left_o and rx_right_o. The outputs hold between pulses, and the first pulse follows the first complete frame after reset.
- R12: During reset the bit clock is high and the frame clock, the serial output, tx_ready_o, rx_valid_o and the received samples are all low. The first bit-clock fall, which starts slot 0 of the first frame, comes at the second rising clock edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_i | input | 2 | Format code 0..3, taken at frame end |
| tx_valid_i | input | 1 | Transmit samples are offered |
| tx_ready_o | output | 1 | Last clock of the frame: transmit samples are taken |
| tx_left_i | input | 20 | Left sample to send |
| tx_right_i | input | 20 | Right sample to send |
| rx_valid_o | output | 1 | One-cycle pulse: a received pair is presented |
| rx_left_o | output | 20 | Received left sample |
| rx_right_o | output | 20 | Received right sample |
| bclk_o | output | 1 | Bit clock to the converter |
| lrclk_o | output | 1 | Left/right frame clock to the converter |
| sdout_o | output | 1 | Serial data to the converter |
| sdin_i | input | 1 | Serial data from the converter |

## Verification
The hardest case is a format change between I2S and a non-I2S code. At that frame boundary the frame clock may not toggle at all, because the left half changes polarity, and a wrong switch point shows up only as bits one slot off. The bench rewrites fmt_i twice inside every frame, first with a decoy value and then with the value intended for the next frame. It follows the frame position by counting bit-clock falls from the first fall after reset, not by watching the frame clock. It models the converter, driving sdin_i with random bits in the slots outside the capture window, so every format pair is met at a boundary while the ignored slots are also exercised.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

    typedef enum logic [1:0] {
        FMT_RJ16  = 2'd0,
        FMT_RJ20  = 2'd1,
        FMT_LJ20  = 2'd2,
        FMT_I2S20 = 2'd3
    } ssp_fmt_e;

    // word width carried under a format
    function automatic int word_bits(ssp_fmt_e f, int short_w, int long_w);
        return (f == FMT_RJ16) ? short_w : long_w;
    endfunction

    // first slot of the outgoing word inside a channel half
    function automatic int out_first_slot(ssp_fmt_e f, int half_slots, int short_w, int long_w);
        case (f)
            FMT_RJ16: return half_slots - short_w;
            FMT_RJ20: return half_slots - long_w;
            FMT_LJ20: return 0;
            default:  return 1;
        endcase
    endfunction

    // first slot of the incoming word inside a channel half
    function automatic int in_first_slot(ssp_fmt_e f);
        return (f == FMT_I2S20) ? 1 : 0;
    endfunction

    function automatic logic in_window(int s, int first, int w);
        return (s >= first) && (s < first + w);
    endfunction

endpackage

// File: rtl/ssp_timing.sv
module ssp_timing
    import ssp_pkg::*;
#(
    parameter int CLK_PER_BIT    = 4,
    parameter int SLOTS_PER_HALF = 32,
    parameter int CNT_W          = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ssp_fmt_e         fmt_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic [CNT_W-1:0] cnt_d_o,
    output logic             frame_last_o,
    output ssp_fmt_e         fmt_q_o,
    output ssp_fmt_e         fmt_d_o,
    output logic             bclk_o,
    output logic             lrclk_o
);
    localparam int FRAME_CLKS = CLK_PER_BIT * SLOTS_PER_HALF * 2;
    localparam logic [CNT_W-1:0] LAST    = CNT_W'(FRAME_CLKS - 1);
    localparam logic [CNT_W-1:0] RST_CNT = CNT_W'(FRAME_CLKS - 2);
    localparam logic RST_BCLK = ((FRAME_CLKS - 2) % CLK_PER_BIT) >= (CLK_PER_BIT / 2);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ssp_fmt_e         fmt;
        logic             bclk;
        logic             lrclk;
    } tim_t;

    tim_t st_q, st_d;

    always_comb begin
        st_d         = st_q;
        frame_last_o = (st_q.cnt == LAST);
        st_d.cnt     = frame_last_o ? '0 : st_q.cnt + 1'b1;
        if (frame_last_o) begin
            st_d.fmt = fmt_i;
        end
        st_d.bclk  = (int'(st_d.cnt) % CLK_PER_BIT) >= (CLK_PER_BIT / 2);
        st_d.lrclk = ((int'(st_d.cnt) / CLK_PER_BIT) >= SLOTS_PER_HALF) ^ (st_d.fmt != FMT_I2S20);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: RST_CNT, fmt: FMT_RJ16, bclk: RST_BCLK, lrclk: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q_o = st_q.cnt;
    assign cnt_d_o = st_d.cnt;
    assign fmt_q_o = st_q.fmt;
    assign fmt_d_o = st_d.fmt;
    assign bclk_o  = st_q.bclk;
    assign lrclk_o = st_q.lrclk;

endmodule

// File: rtl/ssp_tx.sv
module ssp_tx
    import ssp_pkg::*;
#(
    parameter int CLK_PER_BIT    = 4,
    parameter int SLOTS_PER_HALF = 32,
    parameter int SHORT_W        = 16,
    parameter int LONG_W         = 20,
    parameter int CNT_W          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_d_i,
    input  ssp_fmt_e          fmt_d_i,
    input  logic              frame_last_i,
    input  logic              tx_valid_i,
    input  logic [LONG_W-1:0] tx_left_i,
    input  logic [LONG_W-1:0] tx_right_i,
    output logic              tx_ready_o,
    output logic              sdout_o
);
    localparam int IDX_W = $clog2(LONG_W);

    typedef struct packed {
        logic [LONG_W-1:0] left;
        logic [LONG_W-1:0] right;
        logic              sdout;
    } tx_t;

    tx_t st_q, st_d;

    always_comb begin
        int slot;
        int s;
        int first;
        int w;
        int idx;
        logic [LONG_W-1:0] word;
        st_d = st_q;
        if (frame_last_i) begin
            st_d.left  = tx_valid_i ? tx_left_i  : '0;
            st_d.right = tx_valid_i ? tx_right_i : '0;
        end
        slot  = int'(cnt_d_i) / CLK_PER_BIT;
        s     = slot % SLOTS_PER_HALF;
        first = out_first_slot(fmt_d_i, SLOTS_PER_HALF, SHORT_W, LONG_W);
        w     = word_bits(fmt_d_i, SHORT_W, LONG_W);
        word  = (slot >= SLOTS_PER_HALF) ? st_d.right : st_d.left;
        idx   = w - 1 - (s - first);
        st_d.sdout = 1'b0;
        if (in_window(s, first, w)) begin
            st_d.sdout = word[idx[IDX_W-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_ready_o = frame_last_i;
    assign sdout_o    = st_q.sdout;

endmodule

// File: rtl/ssp_rx.sv
module ssp_rx
    import ssp_pkg::*;
#(
    parameter int CLK_PER_BIT    = 4,
    parameter int SLOTS_PER_HALF = 32,
    parameter int SHORT_W        = 16,
    parameter int LONG_W         = 20,
    parameter int CNT_W          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_q_i,
    input  ssp_fmt_e          fmt_q_i,
    input  logic              frame_last_i,
    input  logic              sdin_i,
    output logic              rx_valid_o,
    output logic [LONG_W-1:0] rx_left_o,
    output logic [LONG_W-1:0] rx_right_o
);
    typedef struct packed {
        logic [LONG_W-1:0] shl;
        logic [LONG_W-1:0] shr;
        logic [LONG_W-1:0] outl;
        logic [LONG_W-1:0] outr;
        logic              valid;
        logic              primed;
    } rx_t;

    rx_t st_q, st_d;

    always_comb begin
        int slot;
        int s;
        st_d       = st_q;
        st_d.valid = 1'b0;
        slot = int'(cnt_q_i) / CLK_PER_BIT;
        s    = slot % SLOTS_PER_HALF;
        if ((int'(cnt_q_i) % CLK_PER_BIT) == (CLK_PER_BIT / 2) &&
            in_window(s, in_first_slot(fmt_q_i), word_bits(fmt_q_i, SHORT_W, LONG_W))) begin
            if (slot >= SLOTS_PER_HALF) begin
                st_d.shr = {st_q.shr[LONG_W-2:0], sdin_i};
            end else begin
                st_d.shl = {st_q.shl[LONG_W-2:0], sdin_i};
            end
        end
        if (frame_last_i) begin
            if (st_q.primed) begin
                st_d.outl  = st_q.shl;
                st_d.outr  = st_q.shr;
                st_d.valid = 1'b1;
            end
            st_d.shl    = '0;
            st_d.shr    = '0;
            st_d.primed = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rx_valid_o = st_q.valid;
    assign rx_left_o  = st_q.outl;
    assign rx_right_o = st_q.outr;

endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
    import ssp_pkg::*;
#(
    parameter int CLK_PER_BIT    = 4,
    parameter int SLOTS_PER_HALF = 32,
    parameter int SHORT_W        = 16,
    parameter int LONG_W         = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        fmt_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    input  logic [LONG_W-1:0] tx_left_i,
    input  logic [LONG_W-1:0] tx_right_i,
    output logic              rx_valid_o,
    output logic [LONG_W-1:0] rx_left_o,
    output logic [LONG_W-1:0] rx_right_o,
    output logic              bclk_o,
    output logic              lrclk_o,
    output logic              sdout_o,
    input  logic              sdin_i
);
    localparam int FRAME_CLKS = CLK_PER_BIT * SLOTS_PER_HALF * 2;
    localparam int CNT_W      = $clog2(FRAME_CLKS);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             frame_last;
    ssp_fmt_e         fmt_q, fmt_d;

    ssp_timing #(
        .CLK_PER_BIT(CLK_PER_BIT), .SLOTS_PER_HALF(SLOTS_PER_HALF), .CNT_W(CNT_W)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .fmt_i(ssp_fmt_e'(fmt_i)),
        .cnt_q_o(cnt_q), .cnt_d_o(cnt_d), .frame_last_o(frame_last),
        .fmt_q_o(fmt_q), .fmt_d_o(fmt_d), .bclk_o(bclk_o), .lrclk_o(lrclk_o)
    );

    ssp_tx #(
        .CLK_PER_BIT(CLK_PER_BIT), .SLOTS_PER_HALF(SLOTS_PER_HALF),
        .SHORT_W(SHORT_W), .LONG_W(LONG_W), .CNT_W(CNT_W)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .cnt_d_i(cnt_d), .fmt_d_i(fmt_d),
        .frame_last_i(frame_last), .tx_valid_i(tx_valid_i),
        .tx_left_i(tx_left_i), .tx_right_i(tx_right_i),
        .tx_ready_o(tx_ready_o), .sdout_o(sdout_o)
    );

    ssp_rx #(
        .CLK_PER_BIT(CLK_PER_BIT), .SLOTS_PER_HALF(SLOTS_PER_HALF),
        .SHORT_W(SHORT_W), .LONG_W(LONG_W), .CNT_W(CNT_W)
    ) u_rx (
        .clk(clk), .rst_n(rst_n), .cnt_q_i(cnt_q), .fmt_q_i(fmt_q),
        .frame_last_i(frame_last), .sdin_i(sdin_i),
        .rx_valid_o(rx_valid_o), .rx_left_o(rx_left_o), .rx_right_o(rx_right_o)
    );

endmodule

// File: rtl/ssp_chk.sv
module ssp_chk #(
    parameter int W = 20
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bclk_o,
    input logic         lrclk_o,
    input logic         sdout_o,
    input logic         tx_ready_o,
    input logic         rx_valid_o,
    input logic [W-1:0] rx_left_o,
    input logic [W-1:0] rx_right_o
);
    AST_BCLK_HIGH_TWO: assert property (@(posedge clk) disable iff (!rst_n) $rose(bclk_o) |=> bclk_o); // R1
    AST_BCLK_LOW_TWO: assert property (@(posedge clk) disable iff (!rst_n) $fell(bclk_o) |=> !bclk_o); // R1
    AST_LRCLK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$fell(bclk_o) |-> $stable(lrclk_o)); // R2
    AST_SDOUT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n) !$fell(bclk_o) |-> $stable(sdout_o)); // R8
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) tx_ready_o |=> !tx_ready_o); // R10
    AST_READY_AT_END: assert property (@(posedge clk) disable iff (!rst_n) tx_ready_o |-> bclk_o); // R10
    AST_RXV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid_o |=> !rx_valid_o); // R11
    AST_RXV_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n) rx_valid_o |-> $past(tx_ready_o)); // R11
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid_o |-> ($stable(rx_left_o) && $stable(rx_right_o))); // R11
endmodule

bind codec_serial_port ssp_chk #(.W(LONG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bclk_o(bclk_o), .lrclk_o(lrclk_o), .sdout_o(sdout_o),
    .tx_ready_o(tx_ready_o), .rx_valid_o(rx_valid_o),
    .rx_left_o(rx_left_o), .rx_right_o(rx_right_o)
);

// File: tb/sim_codec_serial_port.sv
module sim_codec_serial_port;
    localparam int FRAME    = 256;
    localparam int N_FRAMES = 48;

    typedef struct {
        logic [1:0]  f;
        logic [19:0] l;
        logic [19:0] r;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  fmt_i = 2'd0;
    logic        tx_valid_i = 1'b1;
    logic        tx_ready_o;
    logic [19:0] tx_left_i = 20'h0;
    logic [19:0] tx_right_i = 20'h0;
    logic        rx_valid_o;
    logic [19:0] rx_left_o, rx_right_o;
    logic        bclk_o, lrclk_o, sdout_o;
    logic        sdin_i = 1'b0;

    codec_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .fmt_i(fmt_i), .tx_valid_i(tx_valid_i),
        .tx_ready_o(tx_ready_o), .tx_left_i(tx_left_i), .tx_right_i(tx_right_i),
        .rx_valid_o(rx_valid_o), .rx_left_o(rx_left_o), .rx_right_o(rx_right_o),
        .bclk_o(bclk_o), .lrclk_o(lrclk_o), .sdout_o(sdout_o), .sdin_i(sdin_i)
    );

    always #10 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    item_t txq[$];
    item_t rxq[$];

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int b_width(logic [1:0] f);
        return (f == 2'd0) ? 16 : 20;
    endfunction
    function automatic int b_tx_first(logic [1:0] f);
        case (f)
            2'd0: return 16;
            2'd1: return 12;
            2'd2: return 0;
            default: return 1;
        endcase
    endfunction
    function automatic int b_rx_first(logic [1:0] f);
        return (f == 2'd3) ? 1 : 0;
    endfunction
    function automatic logic [19:0] b_mask(logic [1:0] f);
        return (f == 2'd0) ? 20'h0FFFF : 20'hFFFFF;
    endfunction

    // driver side: expected items for the scoreboard
    item_t cur_rx;
    task automatic push_tx_expect();
        item_t it;
        it.f = fmt_i;
        it.l = tx_valid_i ? tx_left_i : 20'h0;
        it.r = tx_valid_i ? tx_right_i : 20'h0;
        txq.push_back(it);
    endtask
    task automatic push_rx_frame(input logic [1:0] f);
        item_t it;
        cur_rx.f = f;
        cur_rx.l = 20'($urandom);
        cur_rx.r = 20'($urandom);
        it.f = f;
        it.l = cur_rx.l & b_mask(f);
        it.r = cur_rx.r & b_mask(f);
        rxq.push_back(it);
    endtask

    // monitor state
    logic        prev_bc = 1'b1;
    logic        prev_sd = 1'b0;
    bit          started = 1'b0;
    bit          seen_ready = 1'b0;
    bit          refresh = 1'b0;
    bit          idle_bad, hold_bad;
    int          gslot = 0;
    int          rel_cyc = 0;
    int          since_fall = 0;
    int          since_ready = 0;
    int          frame_idx = 0;
    logic [1:0]  cur_fmt = 2'd0;
    logic [1:0]  pending_fmt = 2'd0;
    logic [19:0] rec_l, rec_r;

    task automatic finish_frame();
        item_t it;
        if (txq.size() == 0) begin
            chk(1'b0, "R10 no transmit item", 0, 1);
        end else begin
            it = txq.pop_front();
            chk(rec_l == (it.l & b_mask(it.f)), "R4 R9 R10 left word", rec_l, it.l & b_mask(it.f));
            chk(rec_r == (it.r & b_mask(it.f)), "R4 R9 R10 right word", rec_r, it.r & b_mask(it.f));
        end
        chk(!idle_bad, "R6 idle slot drove 1", idle_bad, 0);
        chk(!hold_bad, "R8 sdout moved off a fall", hold_bad, 0);
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            rel_cyc++;
            since_fall++;
            since_ready++;
            if (rx_valid_o) begin
                if (rxq.size() == 0) begin
                    chk(1'b0, "R11 pulse without a frame", 1, 0);
                end else begin
                    item_t it;
                    it = rxq.pop_front();
                    chk(rx_left_o == it.l, "R5 R7 R11 left capture", rx_left_o, it.l);
                    chk(rx_right_o == it.r, "R5 R7 R11 right capture", rx_right_o, it.r);
                end
            end
            if (tx_ready_o) begin
                if (seen_ready) chk(since_ready == FRAME, "R10 ready spacing", since_ready, FRAME);
                seen_ready = 1'b1;
                since_ready = 0;
                push_tx_expect();
                pending_fmt = fmt_i;
                refresh = 1'b1;
            end else if (refresh) begin
                refresh = 1'b0;
                tx_left_i = 20'($urandom);
                tx_right_i = 20'($urandom);
            end
            if (prev_bc && !bclk_o) begin
                if (!started) begin
                    started = 1'b1;
                    gslot = 0;
                    chk(rel_cyc == 3, "R12 first fall timing", rel_cyc, 3);
                end else begin
                    chk(since_fall == 4, "R1 bit period", since_fall, 4);
                    gslot = (gslot + 1) % 64;
                end
                since_fall = 0;
                if (gslot == 0) begin
                    if (frame_idx > 0) finish_frame();
                    if (frame_idx == N_FRAMES) done = 1'b1;
                    cur_fmt = pending_fmt;
                    rec_l = 20'h0;
                    rec_r = 20'h0;
                    idle_bad = 1'b0;
                    hold_bad = 1'b0;
                    push_rx_frame(cur_fmt);
                    frame_idx++;
                end
                if (!done) begin
                    int s;
                    int o;
                    int w;
                    bit upper;
                    logic exp_lr;
                    logic [19:0] val;
                    upper = (gslot >= 32);
                    s = gslot % 32;
                    exp_lr = (cur_fmt == 2'd3) ? upper : !upper;
                    if (gslot == 0 || gslot == 32)
                        chk(lrclk_o == exp_lr, "R2 R3 frame clock at half start", lrclk_o, exp_lr);
                    else if (lrclk_o != exp_lr)
                        chk(1'b0, "R2 R3 frame clock level", lrclk_o, exp_lr);
                    o = b_rx_first(cur_fmt);
                    w = b_width(cur_fmt);
                    val = upper ? cur_rx.r : cur_rx.l;
                    if (s >= o && s < o + w) sdin_i = val[w - 1 - (s - o)];
                    else sdin_i = 1'($urandom);
                    // format churn: a decoy mid-frame, then the value for the next frame
                    if (gslot == 10) fmt_i = ~pending_fmt;
                    if (gslot == 50) fmt_i = 2'((frame_idx + frame_idx / 5) % 4);
                    if (gslot == 40) tx_valid_i = (frame_idx % 6 != 4);
                end
            end else if (started && sdout_o !== prev_sd) begin
                hold_bad = 1'b1;
            end
            if (!prev_bc && bclk_o && started) begin
                int s;
                int o;
                int w;
                s = gslot % 32;
                o = b_tx_first(cur_fmt);
                w = b_width(cur_fmt);
                if (s >= o && s < o + w) begin
                    if (gslot >= 32) rec_r[w - 1 - (s - o)] = sdout_o;
                    else rec_l[w - 1 - (s - o)] = sdout_o;
                end else if (sdout_o !== 1'b0) begin
                    idle_bad = 1'b1;
                end
            end
            prev_bc = bclk_o;
            prev_sd = sdout_o;
        end
    end

    initial begin
        tx_left_i = 20'($urandom);
        tx_right_i = 20'($urandom);
        repeat (3) @(negedge clk);
        // R12 reset state
        chk(bclk_o == 1'b1, "R12 reset bclk", bclk_o, 1);
        chk(lrclk_o == 1'b0, "R12 reset lrclk", lrclk_o, 0);
        chk(sdout_o == 1'b0, "R12 reset sdout", sdout_o, 0);
        chk(tx_ready_o == 1'b0, "R12 reset ready", tx_ready_o, 0);
        chk(rx_valid_o == 1'b0, "R12 reset rx valid", rx_valid_o, 0);
        chk(rx_left_o == 20'h0 && rx_right_o == 20'h0, "R12 reset samples", rx_left_o, 0);
        @(posedge clk);
        #2 rst_n = 1'b1;
        wait (done);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (40000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog frames=%0d expected=%0d", frame_idx, N_FRAMES);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule